// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a simple synchronous request port to an external asynchronous static RAM that holds 256K words of 16 bits. A requester offers one access at a time with a valid/ready handshake: an 18-bit word address, a write flag, a two-bit byte-lane mask and 16 bits of write data. Reads come back as a 16-bit word with a single-cycle valid pulse.

The controller drives the memory's strobes with registered outputs: active-low chip select, output enable, write strobe, and separate upper and lower byte strobes. It also drives the address bus and a shared 16-bit data bus with its own driver-enable flag. Access timing is met by counting clock cycles. Two parameters give the read access time and the write pulse width, and the controller converts each into a wait-state count for the clock period it is given. Each write is wrapped in one setup cycle and one hold cycle. The data-bus drivers are only on while output enable is high. Between accesses the memory is deselected so it can fall into its low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, `req_ready` is 1, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are all 1, and `mem_dq_oe` is 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the edge after acceptance until the access has finished. A write occupies 2 + W cycles and a read occupies R cycles.
- R3: A write holds `mem_we_n` low for exactly W = max(1, ceil(T_WR_PS / CLK_PS)) cycles. Throughout that pulse, `mem_ce_n` is low and `mem_oe_n` is high. With the default parameters W is 2, so the pulse lasts 40 ns.
- R4: Byte-lane mask bit 0 selects data bits 7:0 and drives `mem_lb_n` low. Bit 1 selects bits 15:8 and drives `mem_ub_n` low. A write changes only the selected lanes, and the other lane keeps its previous contents.
- R5: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for R = max(1, ceil(T_RD_PS / CLK_PS)) cycles. With the default parameters R is 3. The bus is sampled on the edge that ends this window. `rsp_valid` rises on that same edge, exactly R cycles after the acceptance edge, and lasts one cycle.
- R6: In `rsp_rdata`, a lane whose mask bit was 0 for the read returns zero. A read with mask 0 returns 0x0000.
- R7: The address, the byte strobes and the driven write data are present for one full cycle before `mem_we_n` falls. The controller keeps driving them, with `mem_ce_n` low, for one full cycle after `mem_we_n` rises. They do not change while `mem_we_n` is low.
- R8: `mem_dq_oe` is 1 only while `mem_oe_n` is 1. `mem_oe_n` never falls in a cycle directly after one in which `mem_dq_oe` was 1. As a result, the controller and the memory never drive the bus at the same time.
- R9: Whenever the controller is idle (`req_ready` is 1), `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 and `mem_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | 18 | Memory address bus |
| mem_dq | inout | 16 | Shared data bus |
| mem_dq_oe | output | 1 | Controller is driving `mem_dq` |

## Verification
The bench's memory model returns unknown data until 45 ns after output enable falls. A controller with one wait state too few therefore samples garbage on every read. The model stores a write only when the write strobe rises, using the bus value at that moment. A missing hold cycle therefore stores a floating bus, and a strobe mapped to the wrong lane corrupts the untouched byte in the partial-write sequence. The model also reports any cycle in which its own drivers and `mem_dq_oe` are active together. The bench times the write pulse and the read latency against values it derives from the nanosecond figures, so a wrong rounding in the wait-state count shows up as a length mismatch.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4
    } phase_e;

    // Cycles needed to cover t_ps at a period of clk_ps, never fewer than one.
    function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        if (n < 1) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mask.sv
`timescale 1ns/1ps
module sram_lane_mask #(
    parameter int DW    = 16,
    parameter int LANES = DW / 8
) (
    input  logic [LANES-1:0] lane_n,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    rd_masked
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_masked[l*8 +: 8] = lane_n[l] ? 8'h00 : dq_in[l*8 +: 8];
    end
endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int LANES  = DW / 8,
    parameter int CNT_W  = 2,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic             tmr_last,
    input  logic [DW-1:0]    rd_masked,
    output logic             req_ready,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    wdata,
    output logic             drive,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata
);
    typedef struct packed {
        phase_e           phase;
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic             drive;
        logic             rsp_valid;
        logic [LANES-1:0] lane_n;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase: PH_IDLE, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0,
        rsp_valid: 1'b0, lane_n: '1, addr: '0, wdata: '0, rdata: '0
    };

    seq_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.addr   = req_addr;
                    s_d.wdata  = req_wdata;
                    s_d.ce_n   = 1'b0;
                    s_d.lane_n = ~req_be;
                    if (req_write) begin
                        s_d.phase = PH_WSETUP;
                        s_d.drive = 1'b1;
                    end else begin
                        s_d.phase = PH_RACC;
                        s_d.oe_n  = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_WSETUP: begin
                s_d.phase = PH_WPULSE;
                s_d.we_n  = 1'b0;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(WR_CYC - 1);
            end
            PH_WPULSE: begin
                if (tmr_last) begin
                    s_d.phase = PH_WHOLD;
                    s_d.we_n  = 1'b1;
                end
            end
            PH_WHOLD: begin
                s_d.phase  = PH_IDLE;
                s_d.ce_n   = 1'b1;
                s_d.lane_n = '1;
                s_d.drive  = 1'b0;
            end
            PH_RACC: begin
                if (tmr_last) begin
                    s_d.phase     = PH_IDLE;
                    s_d.rdata     = rd_masked;
                    s_d.rsp_valid = 1'b1;
                    s_d.oe_n      = 1'b1;
                    s_d.ce_n      = 1'b1;
                    s_d.lane_n    = '1;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.phase == PH_IDLE);
    assign ce_n      = s_q.ce_n;
    assign oe_n      = s_q.oe_n;
    assign we_n      = s_q.we_n;
    assign lane_n    = s_q.lane_n;
    assign addr      = s_q.addr;
    assign wdata     = s_q.wdata;
    assign drive     = s_q.drive;
    assign rsp_valid = s_q.rsp_valid;
    assign rsp_rdata = s_q.rdata;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 18,
    parameter int DW        = 16,
    parameter int CLK_PS    = 20000,
    parameter int T_RD_PS   = 45000,
    parameter int T_WR_PS   = 35000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic [DW/8-1:0] req_be,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            mem_ce_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic            mem_ub_n,
    output logic            mem_lb_n,
    output logic [AW-1:0]   mem_addr,
    inout  wire  [DW-1:0]   mem_dq,
    output logic            mem_dq_oe
);
    localparam int LANES  = DW / 8;
    localparam int RD_CYC = int'(wait_cycles(T_RD_PS, CLK_PS));
    localparam int WR_CYC = int'(wait_cycles(T_WR_PS, CLK_PS));
    localparam int TMAX   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W  = (TMAX > 1) ? $clog2(TMAX) : 1;

    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic [LANES-1:0] lane_n;
    logic [DW-1:0]    wdata, rd_masked;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_lane_mask #(.DW(DW), .LANES(LANES)) u_mask (
        .lane_n    (lane_n),
        .dq_in     (mem_dq),
        .rd_masked (rd_masked)
    );

    sram_ctrl_seq #(
        .AW(AW), .DW(DW), .LANES(LANES), .CNT_W(CNT_W),
        .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .tmr_last  (tmr_last),
        .rd_masked (rd_masked),
        .req_ready (req_ready),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .lane_n    (lane_n),
        .addr      (mem_addr),
        .wdata     (wdata),
        .drive     (mem_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[LANES-1];
    assign mem_dq   = mem_dq_oe ? wdata : 'z;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe
);
    p_we_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    p_rd_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n) &&
                             $stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

    p_stable_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && mem_dq_oe &&
                                             $stable(mem_ub_n) && $stable(mem_lb_n)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr)));

    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_release_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_idle_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
    localparam int  T_ACC_NS = 45;
    localparam int  T_WP_NS  = 35;
    localparam int  PER_NS   = 20;
    localparam int  RD_EXP   = (T_ACC_NS + PER_NS - 1) / PER_NS;
    localparam int  WR_EXP   = (T_WP_NS + PER_NS - 1) / PER_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural byte-strobed memory
    logic [15:0] mdl [int];
    logic [15:0] mdl_out = '0;
    logic        mdl_lo = 1'b0, mdl_hi = 1'b0;
    time         t_oe_fall = 0, t_we_fall = 0;

    assign mem_dq[7:0]  = mdl_lo ? mdl_out[7:0]  : 8'hzz;
    assign mem_dq[15:8] = mdl_hi ? mdl_out[15:8] : 8'hzz;

    always @(negedge mem_oe_n) t_oe_fall = $time;
    always @(negedge mem_we_n) t_we_fall = $time;

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            int a;
            logic [15:0] w;
            a = int'(mem_addr);
            w = mdl.exists(a) ? mdl[a] : 16'hxxxx;
            if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq[15:8];
            mdl[a] = w;
            check(($time - t_we_fall) == WR_EXP * PER_NS, "R3 write pulse ns",
                  32'($time - t_we_fall), 32'(WR_EXP * PER_NS));
        end
    end

    always @(negedge clk) begin
        if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
            int a;
            a = int'(mem_addr);
            if (($time - t_oe_fall) >= T_ACC_NS && mdl.exists(a)) mdl_out = mdl[a];
            else                                                 mdl_out = 16'hxxxx;
            mdl_lo = !mem_lb_n;
            mdl_hi = !mem_ub_n;
        end else begin
            mdl_lo = 1'b0;
            mdl_hi = 1'b0;
        end
        if (rst_n && mem_dq_oe && (mdl_lo || mdl_hi))
            check(1'b0, "R8 bus contention", 32'(mem_dq_oe), 32'd0);
    end

    // Shadow contents kept by the bench
    logic [15:0] shadow [int];

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic do_write(input logic [17:0] a, input logic [1:0] be,
                            input logic [15:0] d, input bit chk_len);
        int k;
        logic [15:0] old;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!req_ready) begin
            k++;
            @(negedge clk);
        end
        if (chk_len) check(k == WR_EXP + 2, "R2 write occupancy", 32'(k), 32'(WR_EXP + 2));
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        shadow[int'(a)] = (old & ~lane_mask(be)) | (d & lane_mask(be));
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] be,
                           output logic [15:0] q, input bit chk_len);
        int  k;
        bit  busy_ok;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        req_wdata = 16'($urandom);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && k < 50) begin
            if (req_ready) busy_ok = 1'b0;
            k++;
            @(negedge clk);
        end
        q = rsp_rdata;
        if (chk_len) begin
            check(k == RD_EXP, "R5 read latency", 32'(k), 32'(RD_EXP));
            check(busy_ok, "R2 ready low while busy", 32'(busy_ok), 32'd1);
        end
    endtask

    task automatic read_expect(input logic [17:0] a, input logic [1:0] be,
                               input string tag);
        logic [15:0] q, e;
        do_read(a, be, q, 1'b0);
        e = shadow[int'(a)] & lane_mask(be);
        check(q === e, tag, 32'(q), 32'(e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [17:0] pool [16];
        logic [15:0] q;
        int unsigned seed;
        seed = $urandom(32'h5eed_0042);

        repeat (3) @(negedge clk);
        check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n
              && !mem_dq_oe, "R1 outputs in reset",
              {26'd0, req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h3f);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset",
              {29'd0, req_ready, mem_ce_n, mem_dq_oe}, 32'h6);

        // Directed lane tests
        do_write(18'h00155, 2'b11, 16'hA5C3, 1'b1);
        check(req_ready && mem_ce_n, "R9 deselected after write",
              {30'd0, req_ready, mem_ce_n}, 32'h3);
        do_read(18'h00155, 2'b11, q, 1'b1);
        check(q === 16'hA5C3, "R5 full word read", 32'(q), 32'hA5C3);
        check(req_ready && mem_ce_n && mem_oe_n, "R9 deselected after read",
              {29'd0, req_ready, mem_ce_n, mem_oe_n}, 32'h7);
        do_write(18'h00155, 2'b01, 16'h1122, 1'b0);
        do_read(18'h00155, 2'b11, q, 1'b0);
        check(q === 16'hA522, "R4 lower lane write", 32'(q), 32'hA522);
        do_write(18'h00155, 2'b10, 16'h3344, 1'b0);
        do_read(18'h00155, 2'b11, q, 1'b0);
        check(q === 16'h3322, "R4 upper lane write", 32'(q), 32'h3322);
        do_read(18'h00155, 2'b01, q, 1'b0);
        check(q === 16'h0022, "R6 lower lane read", 32'(q), 32'h0022);
        do_read(18'h00155, 2'b10, q, 1'b0);
        check(q === 16'h3300, "R6 upper lane read", 32'(q), 32'h3300);
        do_read(18'h00155, 2'b00, q, 1'b0);
        check(q === 16'h0000, "R6 no lane read", 32'(q), 32'h0000);
        do_write(18'h00155, 2'b00, 16'hFFFF, 1'b0);
        read_expect(18'h00155, 2'b11, "R4 empty mask write keeps word");

        // Corner addresses, write immediately followed by read (R8 gap)
        do_write(18'h00000, 2'b11, 16'h0F0F, 1'b0);
        do_write(18'h3FFFF, 2'b11, 16'hF00D, 1'b0);
        read_expect(18'h3FFFF, 2'b11, "R5 top address");
        read_expect(18'h00000, 2'b11, "R5 bottom address");

        // Constrained random mix over a small address pool
        pool[0] = 18'h00000;
        pool[1] = 18'h3FFFF;
        for (int i = 2; i < 16; i++) pool[i] = 18'($urandom);
        for (int i = 0; i < 16; i++) do_write(pool[i], 2'b11, 16'($urandom), 1'b0);
        for (int i = 0; i < 300; i++) begin
            logic [17:0] a;
            logic [1:0]  be;
            a  = pool[$urandom % 16];
            be = 2'($urandom);
            if ($urandom % 2 == 0) do_write(a, be, 16'($urandom), (i % 50) == 0);
            else                   read_expect(a, be, "R4 R6 random read-back");
        end
        do_read(pool[3], 2'b11, q, 1'b1);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule